// File: doc/BRIEF.md
# Mailbox and Doorbell Interrupt Unit

This block passes short messages and interrupt requests between a host-side register port and a local-side register port. Both sides can read and write eight shared 32-bit mailboxes. A doorbell register in each direction carries bit-wise requests. The sender sets doorbell bits by writing ones, and the receiver clears them by writing ones.

A single control/status word holds the enable bits. It also reports each interrupt source as read-only active bits. These sources are the two doorbells, per-mailbox flags raised by host writes, a level input from the local side, and two DMA-channel requests. The unit folds the enabled sources into one registered host interrupt output and one registered local interrupt output. A per-channel select input sends each DMA request to one of the two outputs.

Both ports use the same byte offsets: mailbox n at 0x40 + 4·n, host-to-local doorbell at 0x60, local-to-host doorbell at 0x64, control/status at 0x68. Read data is combinational from the addressed register. Writes take effect at the clock edge on which the write enable is high.

Top module: `mbox_irq_unit`

## Requirements
- R1: After reset every mailbox, both doorbells, the control bits and the mailbox flags read as zero, and both interrupt outputs are low.
- R2: Mailbox n (offset 0x40 + 4·n, n = 0..7, word-aligned) can be written and read from either port. If both ports write the same mailbox in one cycle, the host value is kept.
- R3: A host write to mailbox n, n = 0..3, sets flag n (control/status bit 28+n), but only while control bit 3 is 1. Host writes to mailboxes 4..7, and any host write while bit 3 is 0, leave the flags unchanged.
- R4: Flag n clears when the local port reads mailbox n (l_rd high) or writes the control word with bit 28+n set. If a set and a clear of the same flag fall in one cycle, the flag ends set.
- R5: Host-to-local doorbell (0x60): each host write ORs its data in, and each local write clears the bits written as one. Set wins over clear in the same cycle. Status bit 20 is 1 while the doorbell is nonzero.
- R6: Local-to-host doorbell (0x64): each local write ORs its data in, and each host write clears the bits written as one. Set wins over clear in the same cycle. Status bit 13 is 1 while the doorbell is nonzero.
- R7: Only control bits 3, 8, 9, 11, 16, 17, 18 and 19 are writable (mask 0x000F0B08). Writes to every other bit are ignored, and host writes never touch the flags. If both ports write the control word in one cycle, the local value is kept.
- R8: Status bit 15 follows `lint_in`, and status bits 21 and 22 follow `dma_irq[0]` and `dma_irq[1]`.
- R9: `host_irq` is registered. It equals, one cycle late, bit8 & ((bit9 & bit13) | (bit11 & bit15) | (bit18 & dma0 routed to host) | (bit19 & dma1 routed to host)).
- R10: `local_irq` is registered. It equals, one cycle late, bit16 & ((bit17 & bit20) | any flag | (bit18 & dma0 routed local) | (bit19 & dma1 routed local)).
- R11: `dma_to_host[c]` = 1 routes DMA channel c to the host output, and 0 routes it to the local output.
- R12: Unaligned offsets and offsets outside the map read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe (clears mailbox flags) |
| l_addr | input | ADDR_W | Local byte offset |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data (combinational) |
| lint_in | input | 1 | Local interrupt input level |
| dma_irq | input | 2 | DMA channel interrupt levels |
| dma_to_host | input | 2 | Per-channel route: 1 host, 0 local |
| host_irq | output | 1 | Host interrupt output |
| local_irq | output | 1 | Local interrupt output |

## Verification
Two functions can land on the same edge. A host write to a mailbox can meet a local read that clears the flag of that mailbox. A sending-side doorbell set can meet a receiving-side doorbell clear. The bench drives both strobes in the same cycle on overlapping bits and checks the readback. It expects the flag to survive, and it expects the doorbell to equal the old value minus the cleared bits plus the newly set bits. The routing logic is swept over every combination of enable bits, source levels, route selects and doorbell occupancy. Both outputs are compared against the formulas in R9 and R10.

// File: rtl/mbox_irq_unit.sv
module mbox_irq_unit #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [31:0]       l_wdata,
  output logic [31:0]       l_rdata,
  input  logic              lint_in,
  input  logic [1:0]        dma_irq,
  input  logic [1:0]        dma_to_host,
  output logic              host_irq,
  output logic              local_irq
);
  localparam logic [ADDR_W-1:0] A_MB0 = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_DBH = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] A_DBL = ADDR_W'('h64);
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'('h68);
  localparam logic [31:0] CTRL_MASK = 32'h000F_0B08;

  logic [31:0] mbox [8];
  logic [31:0] db_h2l, db_l2h, ctrl, stat, csr_rd;
  logic [3:0]  mbf, mb_set, mb_clr;

  logic h_is_mb, l_is_mb;
  logic [2:0] h_idx, l_idx;
  assign h_is_mb = (h_addr[1:0] == 2'b00) && (h_addr >= A_MB0) && (h_addr < A_DBH);
  assign l_is_mb = (l_addr[1:0] == 2'b00) && (l_addr >= A_MB0) && (l_addr < A_DBH);
  assign h_idx = h_addr[4:2];
  assign l_idx = l_addr[4:2];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!rst_n) mbox[i] <= '0;
      else if (h_wr && h_is_mb && h_idx == 3'(i)) mbox[i] <= h_wdata;
      else if (l_wr && l_is_mb && l_idx == 3'(i)) mbox[i] <= l_wdata;
    end
  end

  always_comb begin
    for (int n = 0; n < 4; n++) begin
      mb_set[n] = ctrl[3] && h_wr && h_is_mb && h_idx == 3'(n);
      mb_clr[n] = (l_rd && l_is_mb && l_idx == 3'(n)) ||
                  (l_wr && l_addr == A_CSR && l_wdata[28+n]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_h2l <= '0;
      db_l2h <= '0;
      ctrl   <= '0;
      mbf    <= '0;
    end else begin
      db_h2l <= (db_h2l & ~((l_wr && l_addr == A_DBH) ? l_wdata : 32'h0)) |
                ((h_wr && h_addr == A_DBH) ? h_wdata : 32'h0);
      db_l2h <= (db_l2h & ~((h_wr && h_addr == A_DBL) ? h_wdata : 32'h0)) |
                ((l_wr && l_addr == A_DBL) ? l_wdata : 32'h0);
      if (l_wr && l_addr == A_CSR)      ctrl <= l_wdata & CTRL_MASK;
      else if (h_wr && h_addr == A_CSR) ctrl <= h_wdata & CTRL_MASK;
      mbf <= mb_set | (mbf & ~mb_clr);
    end
  end

  always_comb begin
    stat        = '0;
    stat[13]    = |db_l2h;
    stat[15]    = lint_in;
    stat[20]    = |db_h2l;
    stat[22:21] = dma_irq;
    stat[31:28] = mbf;
  end
  assign csr_rd = ctrl | stat;

  always_comb begin
    h_rdata = '0;
    if (h_is_mb)             h_rdata = mbox[h_idx];
    else if (h_addr == A_DBH) h_rdata = db_h2l;
    else if (h_addr == A_DBL) h_rdata = db_l2h;
    else if (h_addr == A_CSR) h_rdata = csr_rd;
  end

  always_comb begin
    l_rdata = '0;
    if (l_is_mb)             l_rdata = mbox[l_idx];
    else if (l_addr == A_DBH) l_rdata = db_h2l;
    else if (l_addr == A_DBL) l_rdata = db_l2h;
    else if (l_addr == A_CSR) l_rdata = csr_rd;
  end

  logic host_nxt, local_nxt;
  assign host_nxt = ctrl[8] & ((ctrl[9] & stat[13]) | (ctrl[11] & lint_in) |
                    (ctrl[18] & dma_irq[0] & dma_to_host[0]) |
                    (ctrl[19] & dma_irq[1] & dma_to_host[1]));
  assign local_nxt = ctrl[16] & ((ctrl[17] & stat[20]) | (|mbf) |
                     (ctrl[18] & dma_irq[0] & ~dma_to_host[0]) |
                     (ctrl[19] & dma_irq[1] & ~dma_to_host[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_irq  <= 1'b0;
      local_irq <= 1'b0;
    end else begin
      host_irq  <= host_nxt;
      local_irq <= local_nxt;
    end
  end

  p_host_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(ctrl[8]));
  p_local_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
    local_irq |-> $past(ctrl[16]));
  p_dbh_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_DBH) |=> ((db_h2l & $past(h_wdata)) == $past(h_wdata)));
  p_dbl_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr == A_DBL) |=> ((db_l2h & $past(l_wdata)) == $past(l_wdata)));

  for (genvar n = 0; n < 4; n++) begin : g_flag_chk
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[3] && h_wr && h_addr == ADDR_W'('h40 + 4*n)) |=> mbf[n]);
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mbf[n]) |-> $past((l_rd && l_addr == ADDR_W'('h40 + 4*n)) ||
                              (l_wr && l_addr == A_CSR && l_wdata[28+n])));
  end
endmodule

// File: tb/mbox_irq_unit_tb.sv
module mbox_irq_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_wr = 0, l_wr = 0, l_rd = 0, lint_in = 0;
  logic [7:0] h_addr = 0, l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0, h_rdata, l_rdata;
  logic [1:0] dma_irq = 0, dma_to_host = 0;
  logic host_irq, local_irq;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  mbox_irq_unit #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .lint_in(lint_in), .dma_irq(dma_irq), .dma_to_host(dma_to_host),
    .host_irq(host_irq), .local_irq(local_irq));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic lw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); l_wr = 1; l_addr = a; l_wdata = d;
    @(negedge clk); l_wr = 0;
  endtask

  task automatic lr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); l_rd = 1; l_addr = a; #1 d = l_rdata;
    @(negedge clk); l_rd = 0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    h_addr = a; #1 d = h_rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 'h40; a <= 'h68; a += 4) begin
      hr(8'(a), d); chk("R1 reset readback", d, 0);
    end
    chk("R1 host_irq low", 32'(host_irq), 0);
    chk("R1 local_irq low", 32'(local_irq), 0);

    // R2 mailboxes both directions, flags stay clear (R3 bit3 off)
    for (int n = 0; n < 8; n++) begin
      v = 32'h1357_9BDF * (n + 1);
      hw(8'('h40 + 4*n), v);
      l_addr = 8'('h40 + 4*n); #1 chk("R2 host->local mailbox", l_rdata, v);
      lw(8'('h40 + 4*n), ~v);
      hr(8'('h40 + 4*n), d); chk("R2 local->host mailbox", d, ~v);
    end
    hr(8'h68, d); chk("R3 no flags while bit3 clear", d >> 28, 0);
    @(negedge clk); h_wr = 1; h_addr = 8'h54; h_wdata = 32'hAAAA_0001;
    l_wr = 1; l_addr = 8'h54; l_wdata = 32'h5555_0002;
    @(negedge clk); h_wr = 0; l_wr = 0;
    hr(8'h54, d); chk("R2 same-cycle write host kept", d, 32'hAAAA_0001);

    // R3 flag setting
    hw(8'h68, 32'h8);
    for (int n = 0; n < 8; n++) begin
      hw(8'('h40 + 4*n), 32'(n));
      hr(8'h68, d);
      chk("R3 flag vector", d >> 28, (n < 4) ? ((1 << (n + 1)) - 1) : 32'hF);
    end
    chk("R10 local_irq off without bit16", 32'(local_irq), 0);

    // R7 host writes to flag bits ignored
    hw(8'h68, 32'h0000_0008 | 32'h0000_0000);
    hw(8'h68, 32'hF000_0008);
    hr(8'h68, d); chk("R7 host write to flags ignored", d >> 28, 32'hF);

    // R4 clearing
    lr(8'h44, d);
    hr(8'h68, d); chk("R4 local read clears flag1", d >> 28, 32'hD);
    lw(8'h68, 32'h4000_0008);
    hr(8'h68, d); chk("R4 write-one clears flag2", d >> 28, 32'h9);
    @(negedge clk); h_wr = 1; h_addr = 8'h40; h_wdata = 32'h77;
    l_rd = 1; l_addr = 8'h40;
    @(negedge clk); h_wr = 0; l_rd = 0;
    hr(8'h68, d); chk("R4 set wins over read-clear", d >> 28, 32'h9);
    lr(8'h40, d);
    hr(8'h68, d); chk("R4 read clears flag0", d >> 28, 32'h8);
    lr(8'h50, d);
    hr(8'h68, d); chk("R4 read of mailbox4 leaves flags", d >> 28, 32'h8);
    lw(8'h68, 32'h8000_0008);
    hr(8'h68, d); chk("R4 flags all clear", d >> 28, 0);

    // R10 mailbox flag drives local_irq with one cycle latency
    hw(8'h68, 32'h0001_0008);
    hw(8'h48, 32'h1);
    chk("R10 latency local_irq", 32'(local_irq), 0);
    @(negedge clk);
    chk("R10 flag raises local_irq", 32'(local_irq), 1);
    chk("R9 host_irq unaffected by flag", 32'(host_irq), 0);
    lr(8'h48, d);
    @(negedge clk);
    chk("R10 local_irq drops after clear", 32'(local_irq), 0);

    // R5 host->local doorbell
    hw(8'h60, 32'hF0);
    hr(8'h60, d); chk("R5 doorbell set", d, 32'hF0);
    hr(8'h68, d); chk("R5 active bit20", (d >> 20) & 1, 1);
    lw(8'h60, 32'h30);
    hr(8'h60, d); chk("R5 doorbell clear", d, 32'hC0);
    @(negedge clk); h_wr = 1; h_addr = 8'h60; h_wdata = 32'h0F;
    l_wr = 1; l_addr = 8'h60; l_wdata = 32'h4F;
    @(negedge clk); h_wr = 0; l_wr = 0;
    hr(8'h60, d); chk("R5 same-cycle set and clear", d, 32'h8F);
    lw(8'h60, 32'hFFFF_FFFF);
    hr(8'h68, d); chk("R5 bit20 idle", (d >> 20) & 1, 0);

    // R6 local->host doorbell
    lw(8'h64, 32'h0300_0000);
    hr(8'h68, d); chk("R6 active bit13", (d >> 13) & 1, 1);
    @(negedge clk); l_wr = 1; l_addr = 8'h64; l_wdata = 32'h1;
    h_wr = 1; h_addr = 8'h64; h_wdata = 32'h0100_0001;
    @(negedge clk); h_wr = 0; l_wr = 0;
    hr(8'h64, d); chk("R6 same-cycle set and clear", d, 32'h0200_0001);
    hw(8'h64, 32'hFFFF_FFFF);
    hr(8'h64, d); chk("R6 doorbell cleared", d, 0);

    // R7 writable mask and simultaneous writes
    hw(8'h68, 32'hFFFF_FFFF);
    hr(8'h68, d); chk("R7 writable mask", d, 32'h000F_0B08);
    @(negedge clk); h_wr = 1; h_addr = 8'h68; h_wdata = 32'h100;
    l_wr = 1; l_addr = 8'h68; l_wdata = 32'h10000;
    @(negedge clk); h_wr = 0; l_wr = 0;
    hr(8'h68, d); chk("R7 local wins control write", d, 32'h10000);
    hw(8'h68, 0);

    // R8 input status
    lint_in = 1; dma_irq = 2'b01; #1;
    hr(8'h68, d); chk("R8 input status", d, 32'h0020_8000);
    dma_irq = 2'b10; #1;
    hr(8'h68, d); chk("R8 dma1 status", d, 32'h0040_8000);
    lint_in = 0; dma_irq = 0;

    // R12 unmapped
    hw(8'h41, 32'hDEAD_BEEF);
    hw(8'h70, 32'hDEAD_BEEF);
    hr(8'h41, d); chk("R12 unaligned reads zero", d, 0);
    hr(8'h70, d); chk("R12 out of map reads zero", d, 0);
    hr(8'h40, d); chk("R12 mailbox0 untouched", d, 32'h77);

    // R9/R10/R11 sweep
    for (int db = 0; db < 4; db++) begin
      hw(8'h64, 32'hFFFF_FFFF);
      lw(8'h60, 32'hFFFF_FFFF);
      if (db[0]) lw(8'h64, 32'h10);
      if (db[1]) hw(8'h60, 32'h20);
      for (int c = 0; c < 128; c++) begin
        for (int in = 0; in < 32; in++) begin
          logic c8, c9, c11, c16, c17, c18, c19, eh, el;
          logic [31:0] cw;
          {c19, c18, c17, c16, c11, c9, c8} = 7'(c);
          cw = (32'(c8) << 8) | (32'(c9) << 9) | (32'(c11) << 11) | (32'(c16) << 16) |
               (32'(c17) << 17) | (32'(c18) << 18) | (32'(c19) << 19);
          lint_in = in[0]; dma_irq = 2'(in >> 1); dma_to_host = 2'(in >> 3);
          eh = c8 & ((c9 & db[0]) | (c11 & in[0]) | (c18 & in[1] & in[3]) |
                     (c19 & in[2] & in[4]));
          el = c16 & ((c17 & db[1]) | (c18 & in[1] & ~in[3]) | (c19 & in[2] & ~in[4]));
          hw(8'h68, cw);
          @(negedge clk);
          chk("R9 R11 host_irq sweep", 32'(host_irq), 32'(eh));
          chk("R10 R11 local_irq sweep", 32'(local_irq), 32'(el));
        end
      end
    end
    finish_run();
  end
endmodule